// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiplier

This block multiplies two 32-bit operands over several cycles, for devices that have no hardware multiply blocks. It uses a single adder and recodes the multiplier two bits at a time with radix-4 Booth digits. A mode input picks unsigned or two's-complement operands. The same datapath serves both modes. Only the extension of the operands and one correction term differ between them.

A core that issues a multiply pulses `start` with the operands and the mode, then stalls while `busy` is high. Exactly sixteen iterations later `done` pulses for one cycle. At that point the 64-bit product is on `result_hi`/`result`, and `zero` flags a zero low word. The outputs hold until the next completion, so an instruction that needs only the low word can read it at any time after `done`.

Top module: `booth_mul_iter`

## Requirements
- R1: While rst_n is low at a clock edge, busy and done go low, result and result_hi go to zero and zero goes high.
- R2: A start seen at a clock edge while busy is low loads op_a, op_b and sign_mode, and busy is high after that edge.
- R3: done is high for exactly one cycle, following the 16th clock edge after the accepting edge. busy falls at that same edge, and busy stays high in between.
- R4: With sign_mode = 0, {result_hi, result} equals the unsigned 64-bit product of op_a and op_b, including the all-ones operands.
- R5: With sign_mode = 1, {result_hi, result} equals the two's-complement 64-bit product of op_a and op_b, including the most negative value.
- R6: zero is high exactly when the low word of the latest completed product is zero. It is updated at the same edge that raises done.
- R7: A start while busy is high is ignored: the operation in progress completes on its original schedule with its original operands.
- R8: result, result_hi and zero change only at the edge that raises done, and they hold otherwise.
- R9: A start present in the cycle where done is high is accepted, so back-to-back products lose no cycle.
- R10: Changes to op_a, op_b and sign_mode after the accepting edge have no effect on the product being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a product; taken only while idle |
| sign_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier (Booth-recoded) |
| busy | output | 1 | Product in progress; the core stalls on it |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Low word of the product |
| result_hi | output | 32 | High word of the product |
| zero | output | 1 | Low word of the last product is zero |

## Verification
The completion of one product and the acceptance of the next can fall in the same cycle. The bench provokes this by holding start high across the done pulse. It expects busy to be high in the very next cycle, the finished product to stay readable, and the new product to arrive 16 edges later. A second collision is a start while the block is busy. The bench raises start with different operands and mode during a run and judges that timing and product both follow the first request. A behavioural model with its own counter and a 64-bit reference multiply is compared with every output on every clock.

// File: rtl/booth_pkg.sv
// Package: shared types for the iterative Booth multiplier.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable types.
package booth_pkg;

    // One radix-4 Booth digit, in the set {-2,-1,0,+1,+2}.
    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_POS1 = 3'd1,
        DIG_POS2 = 3'd2,
        DIG_NEG1 = 3'd3,
        DIG_NEG2 = 3'd4
    } booth_digit_e;

endpackage

// File: rtl/booth_recoder.sv
// Module: booth_recoder
// Turns a 3-bit multiplier window {b(2i+1), b(2i), b(2i-1)} into a
// radix-4 Booth digit. Purely combinational.
// Assumes: the caller supplies a zero for b(-1) in the first window.
module booth_recoder
    import booth_pkg::*;
(
    input  logic [2:0]   win,
    output booth_digit_e digit
);

    // Standard radix-4 recoding table.
    always_comb begin
        unique case (win)
            3'b000, 3'b111: digit = DIG_ZERO;
            3'b001, 3'b010: digit = DIG_POS1;
            3'b011:         digit = DIG_POS2;
            3'b100:         digit = DIG_NEG2;
            default:        digit = DIG_NEG1;   // 3'b101, 3'b110
        endcase
    end

endmodule

// File: rtl/booth_ppgen.sv
// Module: booth_ppgen
// Builds one partial product (digit x multiplicand) at PW bits, in
// two's complement. Negation is invert-plus-one, modulo 2**PW.
// Assumes: mcand is already extended to PW bits for the active mode.
module booth_ppgen
    import booth_pkg::*;
#(
    parameter int PW = 64
) (
    input  logic [PW-1:0] mcand,
    input  booth_digit_e  digit,
    output logic [PW-1:0] pp
);

    logic [PW-1:0] dbl;

    // The doubled multiplicand serves for the +2 and -2 digits.
    always_comb dbl = mcand << 1;

    // Select or negate the multiple named by the digit.
    always_comb begin
        unique case (digit)
            DIG_POS1: pp = mcand;
            DIG_POS2: pp = dbl;
            DIG_NEG1: pp = ~mcand + PW'(1);
            DIG_NEG2: pp = ~dbl + PW'(1);
            default:  pp = '0;
        endcase
    end

endmodule

// File: rtl/booth_ctrl.sv
// Module: booth_ctrl
// Sequencer: it accepts a start while idle, counts ITER iterations,
// then raises done for one cycle and drops busy in the same edge.
// Assumes: synchronous active-low reset; start is ignored while busy.
module booth_ctrl #(
    parameter int ITER = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(ITER + 1);

    logic [CW-1:0] cnt;

    // Accept a request only while idle; this includes the done cycle.
    always_comb load = start && !busy;
    // One iteration happens on every busy cycle.
    always_comb step = busy;
    // The final iteration is the one that writes the result.
    always_comb last = busy && (cnt == CW'(ITER - 1));

    // Iteration counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (step) begin
            cnt  <= cnt + CW'(1);
        end
    end

    // Completion pulse, one cycle after the final iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                        // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                        // R3
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);                              // R7
    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                  // R3

endmodule

// File: rtl/booth_mul_iter.sv
// Module: booth_mul_iter (top)
// Iterative radix-4 Booth multiplier. Each busy cycle recodes two
// multiplier bits, adds one partial product to a double-width
// accumulator and shifts the multiplicand left by two.
// Unsigned mode zero-extends both operands. The multiplier's top
// digit, {0,0,b(W-1)}, is then +b(W-1) at weight 2**W. It is folded
// into the final iteration, so the count stays at W/2 in both modes.
// Assumes: W is even; synchronous active-low reset.
module booth_mul_iter
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sign_mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic [W-1:0] result_hi,
    output logic         zero
);

    localparam int ITER = W / 2;
    localparam int PW   = 2 * W;

    logic          load, step, last;
    logic [PW-1:0] mc_q;      // multiplicand, shifted left 2 per step
    logic [W:0]    mr_q;      // {multiplier, b(-1)}, shifted right 2
    logic [PW-1:0] acc_q;
    logic          fix_q;     // unsigned-mode top-digit correction
    logic [PW-1:0] pp, fix_term, acc_nxt, mc_ext;
    booth_digit_e  digit;

    booth_ctrl #(.ITER(ITER)) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .load (load),
        .step (step),
        .last (last),
        .busy (busy),
        .done (done)
    );

    booth_recoder u_rec (
        .win  (mr_q[2:0]),
        .digit(digit)
    );

    booth_ppgen #(.PW(PW)) u_pp (
        .mcand(mc_q),
        .digit(digit),
        .pp   (pp)
    );

    // Extend the multiplicand by sign or by zero for the chosen mode.
    always_comb mc_ext = sign_mode ? {{W{op_a[W-1]}}, op_a} : {{W{1'b0}}, op_a};

    // Correction term: the multiplicand at weight 2**W, used only on the last step.
    always_comb fix_term = (last && fix_q) ? (mc_q << 2) : '0;

    // Next accumulator value: one partial product plus any correction.
    always_comb acc_nxt = acc_q + pp + fix_term;

    // Operand registers: load on accept, shift on each iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q  <= '0;
            mr_q  <= '0;
            fix_q <= 1'b0;
        end else if (load) begin
            mc_q  <= mc_ext;
            mr_q  <= {op_b, 1'b0};
            fix_q <= !sign_mode && op_b[W-1];
        end else if (step) begin
            mc_q  <= mc_q << 2;
            mr_q  <= {2'b00, mr_q[W:2]};
        end
    end

    // Accumulator: clear on accept, add on each iteration.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (load)  acc_q <= '0;
        else if (step)  acc_q <= acc_nxt;
    end

    // Result registers: written once, on the final iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            result_hi <= '0;
            zero      <= 1'b1;
        end else if (last) begin
            result    <= acc_nxt[W-1:0];
            result_hi <= acc_nxt[PW-1:W];
            zero      <= (acc_nxt[W-1:0] == '0);
        end
    end

    AST_OPERAND_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fix_q));                               // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);                             // R8
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(zero) |-> done);                               // R6
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                             // R2

endmodule

// File: tb/booth_mul_iter_bench.sv
module booth_mul_iter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sign_mode = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        busy, done, zero;
    logic [31:0] result, result_hi;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    booth_mul_iter u_booth_mul_iter (
        .clk(clk), .rst_n(rst_n), .start(start), .sign_mode(sign_mode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
        .result(result), .result_hi(result_hi), .zero(zero)
    );

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b, input logic s);
        logic signed [63:0] sa, sb;
        if (s) begin
            sa = {{32{a[31]}}, a};
            sb = {{32{b[31]}}, b};
            return sa * sb;
        end
        return {32'b0, a} * {32'b0, b};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural model: its own counter and a pending product.
    logic        m_busy = 1'b0, m_done = 1'b0, m_zero = 1'b1, m_mode = 1'b0;
    int          m_cnt = 0;
    logic [63:0] m_res = '0, m_pend = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_res = '0; m_zero = 1'b1;
        end else begin
            m_done = 1'b0;
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1'b1; m_cnt = 0; m_mode = sign_mode;
                    m_pend = ref_mul(op_a, op_b, sign_mode);
                end
            end else begin
                m_cnt++;
                if (m_cnt == 16) begin
                    m_busy = 1'b0; m_done = 1'b1;
                    m_res = m_pend; m_zero = (m_pend[31:0] == 32'd0);
                end
            end
        end
    end

    // Compare every output on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R3 busy", 64'(busy), 64'(m_busy));
            chk(done == m_done, "R3 done", 64'(done), 64'(m_done));
            if (m_done) begin
                chk({result_hi, result} == m_res, m_mode ? "R5 product" : "R4 product",
                    {result_hi, result}, m_res);
                chk(zero == m_zero, "R6 zero", 64'(zero), 64'(m_zero));
            end else begin
                chk({result_hi, result} == m_res, "R8 hold", {result_hi, result}, m_res);
                chk(zero == m_zero, "R8 zero hold", 64'(zero), 64'(m_zero));
            end
        end
    end

    task automatic wait_done();
        while (!m_done) @(negedge clk);
    endtask

    // Plain product: one start pulse, then wait for completion.
    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic s);
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = b; sign_mode = s;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 accept", 64'(busy), 64'd1);
        wait_done();
    endtask

    // Product disturbed by starts and operand changes while busy (R7, R10).
    task automatic run_disturbed(input logic [31:0] a, input logic [31:0] b, input logic s);
        logic [63:0] exp;
        exp = ref_mul(a, b, s);
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = b; sign_mode = s;
        @(negedge clk);
        op_a = ~a; op_b = b ^ 32'h5A5A_0F0F; sign_mode = !s;
        for (int i = 0; i < 6; i++) @(negedge clk);
        start = 1'b0;
        wait_done();
        chk({result_hi, result} == exp, "R7 start ignored", {result_hi, result}, exp);
        chk({result_hi, result} == exp, "R10 operands locked", {result_hi, result}, exp);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        logic [63:0] e1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 flags", {62'd0, busy, done}, 64'd0);
        chk({result_hi, result} == 64'd0, "R1 result", {result_hi, result}, 64'd0);
        chk(zero == 1'b1, "R1 zero", 64'(zero), 64'd1);
        rst_n = 1'b1;

        for (int s = 0; s < 2; s++) begin
            run(32'h8000_0000, 32'h8000_0000, 1'(s));
            run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'(s));
            run(32'hFFFF_FFFF, 32'h0000_0001, 1'(s));
            run(32'h8000_0000, 32'hFFFF_FFFF, 1'(s));
            run(32'h7FFF_FFFF, 32'h8000_0000, 1'(s));
            run(32'h0000_0000, 32'hDEAD_BEEF, 1'(s));
            run(32'h0001_0000, 32'h0001_0000, 1'(s));
            run(32'h0000_0007, 32'hFFFF_FFFD, 1'(s));
            run(32'hAAAA_AAAA, 32'h5555_5555, 1'(s));
        end

        lcg = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            run(a, lcg ^ {lcg[15:0], lcg[31:16]}, lcg[7]);
        end

        run_disturbed(32'hFFFF_FFFF, 32'h8000_0001, 1'b0);
        run_disturbed(32'h8000_0000, 32'h0000_0003, 1'b1);

        // Back-to-back: hold start high across the done pulse (R9).
        @(negedge clk);
        start = 1'b1; op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; sign_mode = 1'b0;
        @(negedge clk);
        op_a = 32'h8000_0000; op_b = 32'h8000_0000; sign_mode = 1'b1;
        wait_done();
        e1 = ref_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 back-to-back accept", 64'(busy), 64'd1);
        chk({result_hi, result} == e1, "R9 first product held", {result_hi, result}, e1);
        wait_done();
        e1 = ref_mul(32'h8000_0000, 32'h8000_0000, 1'b1);
        chk({result_hi, result} == e1, "R9 second product", {result_hi, result}, e1);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule